// File: doc/BRIEF.md
# Flash Block Streaming-Program Sequencer

This block is a host-side controller that programs one block of a NOR-style flash device in a single stream and then verifies it. It sends a two-write command setup to the first word address of the target block and waits on the device status register until the device reports it is ready. It then streams a given number of data words from a valid/ready source, with a ready/done status handshake around every word. After the last word it ends the program phase with a terminator write placed outside the block. The same words are then replayed in the same order from an internal buffer as the verify stream. A second terminator write and an exit poll follow, and a final status read decides whether any word failed to program.

A start pulse captures the base word address, the word count and a polling timeout limit. The block raises `busy` while it works and gives a one-cycle `done` at the end, whether the run succeeded or was aborted. Supply and lock failures seen during setup, a failed final status and a poll timeout are reported on separate sticky flags. These flags are cleared only when the next start is accepted.

Top module: `flash_stream_prog`

## Requirements
- R1: After reset, `busy`, `done`, `flash_we`, `flash_re`, `src_ready` and all four error flags are 0.
- R2: An accepted start (`start` high while `busy` is low) produces two writes at the base address: data 16'h0030 first, then data 16'h00D0.
- R3: After setup, the block reads status until bit 7 is 0. If bit 7 reads 1 together with bit 3 (supply error) or bit 1 (locked block), the run aborts: `vpp_err` takes bit 3, `lock_err` takes bit 1, and no data word is requested or written.
- R4: Each stream word is preceded by status reads until bit 0 is 0, then written at the base address, then followed by status reads until bit 0 is 0 again.
- R5: The program phase takes exactly `word_count` words (1 to MAX_WORDS) from the source in arrival order. It ends with a write of 16'hFFFF at the base address with address bit BLK_BITS inverted.
- R6: The verify phase writes the same words in the same order, with no source handshake, and ends with a second 16'hFFFF write at that same outside address.
- R7: After the second terminator, the block reads status until bit 7 is 1, then makes one more status read and copies bit 4 into `prog_err`.
- R8: A poll that reads `timeout_limit` unsuccessful values in a row (limit at least 1) aborts the run with `timeout_err` set.
- R9: Error flags stay set until the next accepted start, which clears all of them. A start while `busy` is high is ignored.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse at the end of each run, and `busy` is low in the cycle after it.
- R11: `flash_we` and `flash_re` are never high together, and `src_ready` is high only during the program phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Run request, accepted when idle |
| base_addr | input | AW | First word address of the target block |
| word_count | input | $clog2(MAX_WORDS+1) | Number of stream words, 1 to MAX_WORDS |
| timeout_limit | input | TW | Unsuccessful reads allowed in one poll |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Block takes the source word this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| vpp_err | output | 1 | Sticky supply error from setup |
| lock_err | output | 1 | Sticky locked-block error from setup |
| prog_err | output | 1 | Sticky program failure from the final status |
| timeout_err | output | 1 | Sticky poll timeout |
| flash_addr | output | AW | Flash bus word address |
| flash_wdata | output | DW | Flash bus write data |
| flash_we | output | 1 | Flash write strobe, one cycle per write |
| flash_re | output | 1 | Flash status read; rdata is sampled in the same cycle |
| flash_rdata | input | DW | Flash status word |

## Verification
On every cycle the assertions check the bus exclusivity of writes and reads and that every write lands either at the base address or at the outside terminator address. They also check that only 16'hFFFF is written outside the block, that the source is never asked for data during verify, the done/busy pulse shape, the clearing and holding of the error flags, and that each error flag rises only right after a status read that carried its bit. The bench alone can show the things that span a whole run: the full write order, that the verify stream replays exactly the words taken from the source, the number of source words taken, and that a timeout fires after exactly the set number of failing reads.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_CONFIRM,
    S_POLL_SETUP,
    S_POLL_RDY,
    S_FETCH,
    S_WRITE,
    S_POLL_DONE,
    S_TERM,
    S_POLL_EXIT,
    S_STATUS,
    S_FIN
  } fsp_state_e;

  localparam logic [15:0] CMD_SETUP   = 16'h0030;
  localparam logic [15:0] CMD_CONFIRM = 16'h00D0;
  localparam logic [15:0] CMD_TERM    = 16'hFFFF;

  localparam int SB_READY = 7;
  localparam int SB_PFAIL = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_LOCK  = 1;
  localparam int SB_BUSY  = 0;

endpackage

// File: rtl/fsp_rst_sync.sv
module fsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fsp_word_buf.sv
module fsp_word_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end

  assign rd_data = mem[idx];

endmodule

// File: rtl/fsp_poll_timer.sv
module fsp_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] limit,
  input  logic          fail,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign expired = fail && (cnt_q == (limit - TW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (!fail) begin
      cnt_d = '0;
    end else if (!expired) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int AW        = 24,
  parameter int BLK_BITS  = 16,
  parameter int MAX_WORDS = 32,
  parameter int TW        = 16,
  parameter int DW        = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [AW-1:0]                base_addr,
  input  logic [$clog2(MAX_WORDS+1)-1:0] word_count,
  input  logic [TW-1:0]                timeout_limit,
  input  logic                         src_valid,
  input  logic [DW-1:0]                src_data,
  output logic                         src_ready,
  output logic                         busy,
  output logic                         done,
  output logic                         vpp_err,
  output logic                         lock_err,
  output logic                         prog_err,
  output logic                         timeout_err,
  output logic [AW-1:0]                flash_addr,
  output logic [DW-1:0]                flash_wdata,
  output logic                         flash_we,
  output logic                         flash_re,
  input  logic [DW-1:0]                flash_rdata,
  output logic                         buf_wr_en,
  output logic [$clog2(MAX_WORDS)-1:0] buf_idx,
  input  logic [DW-1:0]                buf_rd_data,
  output logic [TW-1:0]                poll_limit,
  output logic                         poll_fail,
  input  logic                         poll_expired
);

  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam int IW = $clog2(MAX_WORDS);
  localparam logic [AW-1:0] BLK_FLIP = AW'(1) << BLK_BITS;

  fsp_state_e    state_q, state_d;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] lim_q;
  logic [IW-1:0] idx_q, idx_d;
  logic          verify_q, verify_d;
  logic [DW-1:0] data_q, data_d;
  logic          vpp_q, vpp_d, lock_q, lock_d, prog_q, prog_d, tmo_q, tmo_d;
  logic          cfg_load;
  logic          last_word;
  logic          st_ready, st_pfail, st_vpp, st_lock, st_busy;
  logic          rdata_unused;

  assign st_ready = flash_rdata[SB_READY];
  assign st_pfail = flash_rdata[SB_PFAIL];
  assign st_vpp   = flash_rdata[SB_VPP];
  assign st_lock  = flash_rdata[SB_LOCK];
  assign st_busy  = flash_rdata[SB_BUSY];
  assign rdata_unused = ^{flash_rdata[DW-1:SB_READY+1], flash_rdata[6:5], flash_rdata[2]};

  assign cfg_load  = (state_q == S_IDLE) && start;
  assign last_word = (CW'(idx_q) + CW'(1)) == cnt_q;

  // Bus drive from state
  always_comb begin
    flash_we    = 1'b0;
    flash_re    = 1'b0;
    flash_wdata = '0;
    flash_addr  = base_q;
    case (state_q)
      S_SETUP:   begin flash_we = 1'b1; flash_wdata = DW'(CMD_SETUP);   end
      S_CONFIRM: begin flash_we = 1'b1; flash_wdata = DW'(CMD_CONFIRM); end
      S_WRITE:   begin flash_we = 1'b1; flash_wdata = data_q;           end
      S_TERM: begin
        flash_we    = 1'b1;
        flash_wdata = DW'(CMD_TERM);
        flash_addr  = base_q ^ BLK_FLIP;
      end
      S_POLL_SETUP, S_POLL_RDY, S_POLL_DONE, S_POLL_EXIT, S_STATUS: flash_re = 1'b1;
      default: ;
    endcase
  end

  // Unsuccessful poll read this cycle
  always_comb begin
    case (state_q)
      S_POLL_SETUP:            poll_fail = st_ready && !(st_vpp || st_lock);
      S_POLL_RDY, S_POLL_DONE: poll_fail = st_busy;
      S_POLL_EXIT:             poll_fail = !st_ready;
      default:                 poll_fail = 1'b0;
    endcase
  end

  assign src_ready  = (state_q == S_FETCH) && !verify_q;
  assign buf_wr_en  = src_ready && src_valid;
  assign buf_idx    = idx_q;
  assign poll_limit = lim_q;
  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_FIN);
  assign vpp_err    = vpp_q;
  assign lock_err   = lock_q;
  assign prog_err   = prog_q;
  assign timeout_err = tmo_q;

  // Next state
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    verify_d = verify_q;
    data_d   = data_q;
    vpp_d    = vpp_q;
    lock_d   = lock_q;
    prog_d   = prog_q;
    tmo_d    = tmo_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_SETUP;
          vpp_d   = 1'b0;
          lock_d  = 1'b0;
          prog_d  = 1'b0;
          tmo_d   = 1'b0;
        end
      end
      S_SETUP:   state_d = S_CONFIRM;
      S_CONFIRM: state_d = S_POLL_SETUP;
      S_POLL_SETUP: begin
        if (!st_ready) begin
          state_d  = S_POLL_RDY;
          idx_d    = '0;
          verify_d = 1'b0;
        end else if (st_vpp || st_lock) begin
          vpp_d   = st_vpp;
          lock_d  = st_lock;
          state_d = S_FIN;
        end else if (poll_expired) begin
          tmo_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_POLL_RDY: begin
        if (!st_busy) begin
          state_d = S_FETCH;
        end else if (poll_expired) begin
          tmo_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_FETCH: begin
        if (verify_q) begin
          data_d  = buf_rd_data;
          state_d = S_WRITE;
        end else if (src_valid) begin
          data_d  = src_data;
          state_d = S_WRITE;
        end
      end
      S_WRITE: state_d = S_POLL_DONE;
      S_POLL_DONE: begin
        if (!st_busy) begin
          if (last_word) begin
            state_d = S_TERM;
          end else begin
            idx_d   = idx_q + IW'(1);
            state_d = S_POLL_RDY;
          end
        end else if (poll_expired) begin
          tmo_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_TERM: begin
        if (!verify_q) begin
          verify_d = 1'b1;
          idx_d    = '0;
          state_d  = S_POLL_RDY;
        end else begin
          state_d = S_POLL_EXIT;
        end
      end
      S_POLL_EXIT: begin
        if (st_ready) begin
          state_d = S_STATUS;
        end else if (poll_expired) begin
          tmo_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_STATUS: begin
        prog_d  = st_pfail;
        state_d = S_FIN;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      verify_q <= 1'b0;
      data_q   <= '0;
      vpp_q    <= 1'b0;
      lock_q   <= 1'b0;
      prog_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      verify_q <= verify_d;
      data_q   <= data_d;
      vpp_q    <= vpp_d;
      lock_q   <= lock_d;
      prog_q   <= prog_d;
      tmo_q    <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (cfg_load) begin
      base_q <= base_addr;
      cnt_q  <= word_count;
      lim_q  <= timeout_limit;
    end
  end

endmodule

// File: rtl/flash_stream_prog.sv
module flash_stream_prog #(
  parameter int AW        = 24,
  parameter int BLK_BITS  = 16,
  parameter int MAX_WORDS = 32,
  parameter int TW        = 16,
  parameter int DW        = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [AW-1:0]                  base_addr,
  input  logic [$clog2(MAX_WORDS+1)-1:0] word_count,
  input  logic [TW-1:0]                  timeout_limit,
  input  logic                           src_valid,
  input  logic [DW-1:0]                  src_data,
  output logic                           src_ready,
  output logic                           busy,
  output logic                           done,
  output logic                           vpp_err,
  output logic                           lock_err,
  output logic                           prog_err,
  output logic                           timeout_err,
  output logic [AW-1:0]                  flash_addr,
  output logic [DW-1:0]                  flash_wdata,
  output logic                           flash_we,
  output logic                           flash_re,
  input  logic [DW-1:0]                  flash_rdata
);

  localparam int IW = $clog2(MAX_WORDS);

  logic          rst_n_sync;
  logic          buf_wr_en;
  logic [IW-1:0] buf_idx;
  logic [DW-1:0] buf_rd_data;
  logic [TW-1:0] poll_limit;
  logic          poll_fail;
  logic          poll_expired;

  fsp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fsp_ctrl #(
    .AW(AW), .BLK_BITS(BLK_BITS), .MAX_WORDS(MAX_WORDS), .TW(TW), .DW(DW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .start         (start),
    .base_addr     (base_addr),
    .word_count    (word_count),
    .timeout_limit (timeout_limit),
    .src_valid     (src_valid),
    .src_data      (src_data),
    .src_ready     (src_ready),
    .busy          (busy),
    .done          (done),
    .vpp_err       (vpp_err),
    .lock_err      (lock_err),
    .prog_err      (prog_err),
    .timeout_err   (timeout_err),
    .flash_addr    (flash_addr),
    .flash_wdata   (flash_wdata),
    .flash_we      (flash_we),
    .flash_re      (flash_re),
    .flash_rdata   (flash_rdata),
    .buf_wr_en     (buf_wr_en),
    .buf_idx       (buf_idx),
    .buf_rd_data   (buf_rd_data),
    .poll_limit    (poll_limit),
    .poll_fail     (poll_fail),
    .poll_expired  (poll_expired)
  );

  fsp_word_buf #(.DEPTH(MAX_WORDS), .DW(DW)) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr_en),
    .idx     (buf_idx),
    .wr_data (src_data),
    .rd_data (buf_rd_data)
  );

  fsp_poll_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .limit   (poll_limit),
    .fail    (poll_fail),
    .expired (poll_expired)
  );

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int AW       = 24,
  parameter int BLK_BITS = 16,
  parameter int DW       = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          vpp_err,
  input logic          lock_err,
  input logic          prog_err,
  input logic          timeout_err,
  input logic          src_ready,
  input logic          verify_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] flash_addr,
  input logic [DW-1:0] flash_wdata,
  input logic          flash_we,
  input logic          flash_re,
  input logic [DW-1:0] flash_rdata
);

  logic accept;
  assign accept = start && !busy;

  assert_bus_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_we && flash_re));

  assert_src_program_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (busy && !verify_q));

  assert_write_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_we |-> ((flash_addr == base_q) || (flash_addr == (base_q ^ (AW'(1) << BLK_BITS)))));

  assert_outside_is_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_we && (flash_addr != base_q)) |-> (flash_wdata == 16'hFFFF));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !vpp_err && !lock_err && !prog_err && !timeout_err));

  assert_vpp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_err && !accept) |=> vpp_err);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err && !accept) |=> lock_err);

  assert_prog_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && !accept) |=> prog_err);

  assert_tmo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !accept) |=> timeout_err);

  assert_vpp_from_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_err) |-> ($past(flash_re) && $past(flash_rdata[3])));

  assert_lock_from_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> ($past(flash_re) && $past(flash_rdata[1])));

  assert_prog_from_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_err) |-> ($past(flash_re) && $past(flash_rdata[4])));

  assert_tmo_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(flash_re));

endmodule

bind fsp_ctrl fsp_checker #(.AW(AW), .BLK_BITS(BLK_BITS), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .vpp_err     (vpp_err),
  .lock_err    (lock_err),
  .prog_err    (prog_err),
  .timeout_err (timeout_err),
  .src_ready   (src_ready),
  .verify_q    (verify_q),
  .base_q      (base_q),
  .flash_addr  (flash_addr),
  .flash_wdata (flash_wdata),
  .flash_we    (flash_we),
  .flash_re    (flash_re),
  .flash_rdata (flash_rdata)
);

// File: tb/flash_stream_prog_tb.sv
module flash_stream_prog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 24;
  localparam int BLK  = 16;
  localparam int MAXW = 32;
  localparam int TW   = 16;
  localparam int DW   = 16;
  localparam int CW   = $clog2(MAXW + 1);

  logic          clk, rst_n, start;
  logic [AW-1:0] base_addr;
  logic [CW-1:0] word_count;
  logic [TW-1:0] timeout_limit;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready, busy, done;
  logic          vpp_err, lock_err, prog_err, timeout_err;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_wdata;
  logic          flash_we, flash_re;
  logic [DW-1:0] flash_rdata;

  flash_stream_prog u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .timeout_limit(timeout_limit),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .busy(busy), .done(done), .vpp_err(vpp_err), .lock_err(lock_err),
    .prog_err(prog_err), .timeout_err(timeout_err), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_we(flash_we), .flash_re(flash_re),
    .flash_rdata(flash_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit fin    = 0;

  // Device model knobs (set by the run task)
  int            k_n, k_setup, k_exit, k_wordmax;
  bit            k_vpp, k_lock, k_fail, k_stuck;
  logic [AW-1:0] k_base;
  logic [DW-1:0] words [MAXW];

  // Device model state
  logic          mrst;
  int            m_mode, pend, terms, nlog, nsrc, nreads;
  int            viol = 0;
  logic [AW-1:0] log_addr [80];
  logic [DW-1:0] log_data [80];

  always @(posedge clk) begin
    if (mrst) begin
      m_mode <= 0; pend <= 0; terms <= 0; nlog <= 0; nsrc <= 0; nreads <= 0;
    end else begin
      if (flash_re) begin
        nreads <= nreads + 1;
        if (pend > 0) pend <= pend - 1;
      end
      if (src_valid && src_ready) nsrc <= nsrc + 1;
      if (flash_we) begin
        if (nlog < 80) begin
          log_addr[nlog] <= flash_addr;
          log_data[nlog] <= flash_wdata;
        end
        nlog <= nlog + 1;
        if (m_mode == 0) begin
          if (flash_wdata == 16'h00D0) begin m_mode <= 1; pend <= k_setup; end
        end else if ((flash_addr >> BLK) != (k_base >> BLK)) begin
          terms <= terms + 1;
          if (terms >= 1) begin m_mode <= 2; pend <= k_exit; end
          else pend <= 0;
        end else begin
          pend <= int'($urandom_range(k_wordmax, 0));
        end
      end
      if (flash_we && flash_re) viol <= viol + 1;
      if (src_ready && terms >= 1) viol <= viol + 1;
    end
  end

  always_comb begin
    flash_rdata = '0;
    if (m_mode == 2) flash_rdata[7] = (pend == 0);
    else             flash_rdata[7] = (pend > 0) || k_vpp || k_lock;
    flash_rdata[0] = k_stuck || (pend > 0);
    flash_rdata[4] = k_fail;
    flash_rdata[3] = k_vpp;
    flash_rdata[1] = k_lock;
  end

  always @(negedge clk) begin
    src_data  = (nsrc < MAXW) ? words[nsrc] : '0;
    src_valid = (nsrc < k_n) && ($urandom_range(2, 0) != 0);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !fin) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual no end of test, expected end before cycle 150000");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int n, input logic [AW-1:0] base, input int sw, input int wm,
                     input int ew, input bit vpp, input bit lock, input bit pfail,
                     input bit stuck, input int lim, input int extra_start);
    bit abort, full;
    int cnt;
    logic [AW-1:0] term;
    k_n = n; k_base = base; k_setup = sw; k_wordmax = wm; k_exit = ew;
    k_vpp = vpp; k_lock = lock; k_fail = pfail; k_stuck = stuck;
    for (int i = 0; i < MAXW; i++) words[i] = DW'($urandom);
    @(negedge clk); mrst = 1'b1;
    @(negedge clk); mrst = 1'b0;
    base_addr = base; word_count = CW'(n); timeout_limit = TW'(lim); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 busy after start", 32'(busy), 1);
    chk("R9 errors cleared by start", {28'd0, vpp_err, lock_err, prog_err, timeout_err}, 0);
    cnt = 0;
    while (!done && cnt < 20000) begin
      start = (cnt == extra_start);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk("R10 done reached", 32'(done), 1);
    abort = vpp || lock;
    full  = !abort && !stuck;
    term  = base ^ (AW'(1) << BLK);
    chk("R3 vpp_err", 32'(vpp_err), 32'(vpp));
    chk("R3 lock_err", 32'(lock_err), 32'(lock));
    chk("R8 timeout_err", 32'(timeout_err), 32'(stuck && !abort));
    chk("R7 prog_err", 32'(prog_err), 32'(pfail && full));
    chk("R5 write count", 32'(nlog), full ? 32'(2 * n + 4) : 32'd2);
    chk("R5 source words taken", 32'(nsrc), full ? 32'(n) : 32'd0);
    chk("R2 setup addr", 32'(log_addr[0]), 32'(base));
    chk("R2 setup data", 32'(log_data[0]), 32'h30);
    chk("R2 confirm addr", 32'(log_addr[1]), 32'(base));
    chk("R2 confirm data", 32'(log_data[1]), 32'hD0);
    if (full) begin
      for (int i = 0; i < n; i++) begin
        chk("R4 program word addr", 32'(log_addr[2 + i]), 32'(base));
        chk("R5 program word data", 32'(log_data[2 + i]), 32'(words[i]));
        chk("R4 verify word addr", 32'(log_addr[3 + n + i]), 32'(base));
        chk("R6 verify word data", 32'(log_data[3 + n + i]), 32'(words[i]));
      end
      chk("R5 first term addr", 32'(log_addr[2 + n]), 32'(term));
      chk("R5 first term data", 32'(log_data[2 + n]), 32'hFFFF);
      chk("R6 second term addr", 32'(log_addr[3 + 2 * n]), 32'(term));
      chk("R6 second term data", 32'(log_data[3 + 2 * n]), 32'hFFFF);
    end
    if (stuck && !abort) chk("R8 failing reads before timeout", 32'(nreads), 32'(sw + 1 + lim));
    @(negedge clk);
    chk("R10 idle after done", {30'd0, busy, done}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; mrst = 1'b1;
    base_addr = '0; word_count = '0; timeout_limit = '0;
    k_n = 0; k_base = '0; k_setup = 0; k_exit = 0; k_wordmax = 0;
    k_vpp = 0; k_lock = 0; k_fail = 0; k_stuck = 0;
    for (int i = 0; i < MAXW; i++) words[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mrst = 1'b0;
    chk("R1 reset outputs", {25'd0, busy, done, flash_we, flash_re, src_ready,
                             (vpp_err | lock_err), (prog_err | timeout_err)}, 0);
    // directed corners
    run(1,    24'h000000, 0, 0, 0, 0, 0, 0, 0, 100, -1);
    run(MAXW, 24'h3A0000, 3, 4, 5, 0, 0, 0, 0, 100, -1);
    run(5,    24'h120040, 2, 2, 2, 1, 0, 0, 0, 100, -1);   // supply error abort
    run(5,    24'h120040, 2, 2, 2, 0, 1, 0, 0, 100, -1);   // locked block abort
    run(4,    24'h450000, 2, 2, 2, 0, 0, 0, 1, 5,   -1);   // stuck busy bit, timeout
    run(6,    24'h00FF00, 1, 3, 3, 0, 0, 1, 0, 100, -1);   // final status failure
    run(8,    24'h7F0001, 1, 2, 2, 0, 0, 0, 0, 100, 12);   // start mid-run ignored R9
    // random runs
    for (int r = 0; r < 8; r++) begin
      run(int'($urandom_range(MAXW, 1)), AW'($urandom), int'($urandom_range(6, 0)),
          int'($urandom_range(5, 0)), int'($urandom_range(6, 0)), 0, 0,
          bit'($urandom_range(1, 0)), 0, 100, -1);
    end
    chk("R11 bus exclusivity and source gating", 32'(viol), 0);
    fin = 1;
    summary();
    $finish;
  end

endmodule